// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block turns the interrupt events of a 16550-style serial port into one interrupt request line and one identification byte. Five sources are weighed: receiver line errors, received data at or above the trigger level, a character timeout, an empty transmit holding register and a change on the modem status lines. Four enable bits decide which sources may raise the request. Of the enabled and pending sources, the most urgent is encoded into the identification byte. That byte also shows a not-pending flag and a signature meaning that the FIFOs are on.

The unit also applies the side effects of host accesses. A line status read drops the error source. A modem status read drops the modem source. A transmit holding write, or an identification read that is reporting the transmit source, drops the holding-empty source. The host reads the identification byte in a loop until bit 0 returns to 1, so every source stays asserted until its own clearing access.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq_o` is 0 and `iir_o` reads 0x01.
- R2: `iir_o[0]` is 1 exactly when nothing enabled is pending, and `irq_o` is always its inverse. Both are registered and show an event or a clearing access at the clock edge that samples it.
- R3: Enable bit 0 gates received data and timeout, bit 1 gates holding-empty, bit 2 gates line status and bit 3 gates modem status. Codes in `iir_o[3:0]` are 0x6 line status, 0x4 received data, 0xC timeout, 0x2 holding-empty and 0x0 modem status.
- R4: The priority runs from line status, then received data or timeout, then holding-empty, down to modem status.
- R5: When the timeout and the received-data level are both high, the timeout code 0xC is reported.
- R6: `iir_o[7:6]` both read 1 while `fifo_en_i` is high and 0 otherwise. `iir_o[5:4]` always read 0.
- R7: A pulse on `line_err_i` latches the line status source until a pulse on `lsr_rd_i`. An error arriving in the same cycle as the read stays latched.
- R8: A pulse on `msr_chg_i` latches the modem source until a pulse on `msr_rd_i`. A change in the same cycle as the read stays latched.
- R9: The received-data and timeout sources follow the `rx_trig_i` and `rx_tmo_i` levels, so they clear when the receive side drains.
- R10: The holding-empty source is set when `thr_empty_i` rises. It is cleared by `thr_wr_i`, or by `iir_rd_i` while `iir_o[3:0]` is 0x2 with bit 0 low.
- R11: The holding-empty source is set when enable bit 1 goes from 0 to 1 while `thr_empty_i` is high.
- R12: A latched source survives while its enable is low, and while a higher source is reported. An identification read that reports some other code leaves the holding-empty source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFOs enabled |
| line_err_i | input | 1 | Pulse: a receiver line error was detected |
| rx_trig_i | input | 1 | Level: receive data at or above the trigger level |
| rx_tmo_i | input | 1 | Level: character timeout pending |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| msr_chg_i | input | 1 | Pulse: a modem status line changed |
| lsr_rd_i | input | 1 | Pulse: host read of line status |
| msr_rd_i | input | 1 | Pulse: host read of modem status |
| iir_rd_i | input | 1 | Pulse: host read of the identification byte |
| thr_wr_i | input | 1 | Pulse: host write to the transmit holding register |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
Sources are stacked one by one from lowest to highest priority, then removed in reverse. Each step shows whether the encoder ranks them correctly or only reports the newest event. Clearing accesses are applied while other sources are reported, and at the same moment as a new event. These steps separate correct latching from a clear that wipes too much or loses a fresh error. Toggling the enables while sources are latched shows whether gating hides a source or discards it, and whether raising the holding-empty enable re-arms that source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef logic [3:0] irq_code_t;
   localparam irq_code_t CODE_LINE  = 4'h6;
   localparam irq_code_t CODE_RXDAT = 4'h4;
   localparam irq_code_t CODE_TMO   = 4'hC;
   localparam irq_code_t CODE_THRE  = 4'h2;
   localparam irq_code_t CODE_MODEM = 4'h0;
   localparam irq_code_t CODE_IDLE  = 4'h1;
   localparam int EN_RX    = 0;
   localparam int EN_THRE  = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic nxt_o,
   output logic q_o
);
   generate
      if (SET_WINS) begin : g_set_wins
         assign nxt_o = set_i | (q_o & ~clr_i);
      end else begin : g_clr_wins
         assign nxt_o = ~clr_i & (set_i | q_o);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= nxt_o;
   end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic empty_i,
   input  logic wr_i,
   input  logic ack_i,
   output logic nxt_o,
   output logic q_o
);
   logic empty_q, en_q, arm;

   assign arm   = (empty_i & ~empty_q) | (empty_i & en_i & ~en_q);
   assign nxt_o = (wr_i | ack_i) ? 1'b0 : (arm | q_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o     <= 1'b0;
         empty_q <= 1'b1;
         en_q    <= 1'b0;
      end else begin
         q_o     <= nxt_o;
         empty_q <= empty_i;
         en_q    <= en_i;
      end
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int IER_W       = 4,
   parameter bit TMO_SUPPORT = 1'b1
) (
   input  logic [IER_W-1:0] ier_i,
   input  logic             line_i,
   input  logic             rx_i,
   input  logic             tmo_i,
   input  logic             thre_i,
   input  logic             modem_i,
   output irq_code_t        code_o
);
   logic tmo_eff;

   generate
      if (TMO_SUPPORT) begin : g_tmo
         assign tmo_eff = tmo_i;
      end else begin : g_no_tmo
         assign tmo_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      if (line_i && ier_i[EN_LINE])             code_o = CODE_LINE;
      else if (tmo_eff && ier_i[EN_RX])         code_o = CODE_TMO;
      else if (rx_i && ier_i[EN_RX])            code_o = CODE_RXDAT;
      else if (thre_i && ier_i[EN_THRE])        code_o = CODE_THRE;
      else if (modem_i && ier_i[EN_MODEM])      code_o = CODE_MODEM;
      else                                      code_o = CODE_IDLE;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int IER_W       = 4,
   parameter int IIR_W       = 8,
   parameter bit TMO_SUPPORT = 1'b1,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IER_W-1:0] ier_i,
   input  logic             fifo_en_i,
   input  logic             line_err_i,
   input  logic             rx_trig_i,
   input  logic             rx_tmo_i,
   input  logic             thr_empty_i,
   input  logic             msr_chg_i,
   input  logic             lsr_rd_i,
   input  logic             msr_rd_i,
   input  logic             iir_rd_i,
   input  logic             thr_wr_i,
   output logic             irq_o,
   output logic [IIR_W-1:0] iir_o
);
   localparam int SIG_LO = IIR_W - 2;

   generate
      if (IIR_W != 8) begin : g_bad_iir_w
         $error("identification byte must be 8 bits wide");
      end
      if (IER_W < 4) begin : g_bad_ier_w
         $error("at least four enable bits are needed");
      end
   endgenerate

   logic      line_nxt, line_q, modem_nxt, modem_q, thre_nxt, thre_q, thre_ack;
   irq_code_t code_nxt;

   assign thre_ack = iir_rd_i && !iir_o[0] && (iir_o[3:0] == CODE_THRE);

   uart_irq_flag #(.SET_WINS(SET_WINS)) u_line (
      .clk(clk), .rst_n(rst_n), .set_i(line_err_i), .clr_i(lsr_rd_i),
      .nxt_o(line_nxt), .q_o(line_q));

   uart_irq_flag #(.SET_WINS(SET_WINS)) u_modem (
      .clk(clk), .rst_n(rst_n), .set_i(msr_chg_i), .clr_i(msr_rd_i),
      .nxt_o(modem_nxt), .q_o(modem_q));

   uart_irq_thre u_thre (
      .clk(clk), .rst_n(rst_n), .en_i(ier_i[EN_THRE]), .empty_i(thr_empty_i),
      .wr_i(thr_wr_i), .ack_i(thre_ack), .nxt_o(thre_nxt), .q_o(thre_q));

   uart_irq_prio #(.IER_W(IER_W), .TMO_SUPPORT(TMO_SUPPORT)) u_prio (
      .ier_i(ier_i), .line_i(line_nxt), .rx_i(rx_trig_i), .tmo_i(rx_tmo_i),
      .thre_i(thre_nxt), .modem_i(modem_nxt), .code_o(code_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iir_o <= IIR_W'(CODE_IDLE);
         irq_o <= 1'b0;
      end else begin
         iir_o <= {{2{fifo_en_i}}, {(SIG_LO-4){1'b0}}, code_nxt};
         irq_o <= ~code_nxt[0];
      end
   end

   a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (iir_o[3:0] == CODE_IDLE));
   a_r3_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i[3:0] == 4'h0) |=> !irq_o);
   a_r6_fifo_sig: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en_i |=> (iir_o[7:6] == 2'b11));
   a_r7_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i[EN_LINE] && !iir_o[0] && iir_o[3:0] == CODE_LINE && !lsr_rd_i)
      |=> (iir_o[3:0] == CODE_LINE));
   a_r7_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd_i && !line_err_i) |=> (iir_o[3:0] != CODE_LINE));
   a_r8_modem_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd_i && !msr_chg_i) |=> (iir_o[3:0] != CODE_MODEM));
   a_r10_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr_i |=> (iir_o[3:0] != CODE_THRE));
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] ier = 4'h0;
   logic fifo_en = 0, line_err = 0, rx_trig = 0, rx_tmo = 0, thr_empty = 1;
   logic msr_chg = 0, lsr_rd = 0, msr_rd = 0, iir_rd = 0, thr_wr = 0;
   logic irq;
   logic [7:0] iir;
   int checks = 0, failures = 0, cycles = 0;

   always #10 clk = ~clk;

   uart_irq_ident uut (
      .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
      .line_err_i(line_err), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
      .thr_empty_i(thr_empty), .msr_chg_i(msr_chg), .lsr_rd_i(lsr_rd),
      .msr_rd_i(msr_rd), .iir_rd_i(iir_rd), .thr_wr_i(thr_wr),
      .irq_o(irq), .iir_o(iir));

   // behavioural reference
   bit m_line, m_modem, m_thre, m_prev_empty = 1, m_prev_en = 0;
   logic [7:0] m_iir = 8'h01;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_line = 0; m_modem = 0; m_thre = 0; m_prev_empty = 1; m_prev_en = 0;
         m_iir = 8'h01;
      end else begin
         automatic bit rd_thre = iir_rd && (m_iir[3:0] == 4'h2);
         automatic logic [3:0] c;
         if (line_err) m_line = 1; else if (lsr_rd) m_line = 0;
         if (msr_chg) m_modem = 1; else if (msr_rd) m_modem = 0;
         if (thr_wr || rd_thre) m_thre = 0;
         else if ((thr_empty && !m_prev_empty) || (thr_empty && ier[1] && !m_prev_en)) m_thre = 1;
         m_prev_empty = thr_empty; m_prev_en = ier[1];
         c = 4'h1;
         if (m_modem && ier[3]) c = 4'h0;
         if (m_thre && ier[1]) c = 4'h2;
         if (rx_trig && ier[0]) c = 4'h4;
         if (rx_tmo && ier[0]) c = 4'hC;
         if (m_line && ier[2]) c = 4'h6;
         m_iir = {fifo_en, fifo_en, 2'b00, c};
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (iir !== m_iir || irq !== ~m_iir[0]) begin
            failures++;
            $display("FAIL R4 model compare: iir=%h irq=%b expected iir=%h irq=%b",
                     iir, irq, m_iir, ~m_iir[0]);
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] exp);
      checks++;
      if (iir !== exp || irq !== ~exp[0]) begin
         failures++;
         $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b (R2)", tag, iir, irq, exp, ~exp[0]);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      line_err = 0; msr_chg = 0; lsr_rd = 0; msr_rd = 0; iir_rd = 0; thr_wr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1 reset", 8'h01);
      ier = 4'hF; tick(); chk("R11 enable rise arms thre", 8'h02);
      iir_rd = 1; tick(); chk("R10 iir read clears thre", 8'h01);
      thr_wr = 1; thr_empty = 0; tick(); chk("R10 write", 8'h01);
      thr_empty = 1; tick(); chk("R10 empty rise", 8'h02);
      thr_wr = 1; thr_empty = 0; tick(); chk("R10 write clears", 8'h01);
      msr_chg = 1; tick(); chk("R3 modem code", 8'h00);
      rx_trig = 1; tick(); chk("R4 rx over modem", 8'h04);
      rx_tmo = 1; tick(); chk("R5 timeout over data", 8'h0C);
      line_err = 1; tick(); chk("R4 line on top", 8'h06);
      lsr_rd = 1; tick(); chk("R7 lsr read clears", 8'h0C);
      rx_tmo = 0; rx_trig = 0; tick(); chk("R9 drained", 8'h00);
      iir_rd = 1; tick(); chk("R12 iir read keeps modem", 8'h00);
      msr_rd = 1; msr_chg = 1; tick(); chk("R8 change beats read", 8'h00);
      msr_rd = 1; tick(); chk("R8 msr read clears", 8'h01);
      line_err = 1; lsr_rd = 1; tick(); chk("R7 error beats read", 8'h06);
      lsr_rd = 1; tick(); chk("R7 cleared", 8'h01);
      fifo_en = 1; tick(); chk("R6 fifo signature", 8'hC1);
      ier = 4'h0; line_err = 1; tick(); chk("R3 gated off", 8'hC1);
      ier = 4'h4; tick(); chk("R12 latched while disabled", 8'hC6);
      lsr_rd = 1; tick(); chk("R7 clear", 8'hC1);
      thr_empty = 1; ier = 4'h3; rx_trig = 1; tick(); chk("R4 rx over thre", 8'hC4);
      iir_rd = 1; tick(); chk("R12 read of other code", 8'hC4);
      rx_trig = 0; tick(); chk("R12 thre still pending", 8'hC2);
      ier = 4'h1; tick(); chk("R3 thre gated", 8'hC1);
      ier = 4'h3; tick(); chk("R11 re-arm on enable", 8'hC2);
      fifo_en = 0; rx_tmo = 1; tick(); chk("R9 timeout level", 8'h0C);
      rx_tmo = 0; tick(); chk("R9 timeout gone", 8'h02);
      tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         failures++;
         $display("FAIL watchdog: cycles=%0d expected under 5000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule